// File: doc/BRIEF.md
# Conflict-Only Instruction Cache

This block sits between a program sequencer and a single program-memory bus. That bus carries instruction fetches and also data transfers. When a fetch misses while a data transfer wants the bus in the same cycle, the two collide. In that case the data transfer takes the bus, the fetch stalls for one cycle, and in the next cycle the instruction is read from memory and written into a small 2-way set-associative store.

Any later fetch of that address that hits is answered from the store, so the bus stays free for data. One instruction and two operands then move in the same cycle. A tight loop that loads data through this bus pays the stall only on its first pass. After that it runs at one instruction per cycle.

A miss with no colliding data transfer reads memory directly in the same cycle and stores nothing. A freeze input stops new entries from being written. A flush input drops every entry in a single cycle.

Top module: `icc_conflict_cache`

## Requirements
- R1: After reset the cache holds no valid entries, and with no fetch request `instr_valid`, `fetch_stall` and `bus_ifetch` are all 0.
- R2: A missing fetch with `data_req` low is answered in the same cycle. `bus_ifetch` is 1, `bus_addr` equals `fetch_addr`, and `instr_data` equals `bus_rdata`. Nothing is allocated, so a later colliding fetch of the same address still misses.
- R3: A missing fetch with `data_req` high is a conflict. In that cycle `fetch_stall` is 1, `data_grant` is 1 and `instr_valid` is 0. In the next cycle `bus_ifetch` is 1, `data_grant` is 0, `instr_valid` is 1 and `instr_data` equals `bus_rdata`.
- R4: The instruction read during a conflict refill is stored. A later fetch of that address hits: `instr_valid` is 1, there is no stall, `bus_ifetch` is 0, `data_grant` follows `data_req`, and `instr_data` is the stored word even if memory has changed since.
- R5: The store has ENTRIES/2 sets of 2 ways. The set index is the low log2(ENTRIES/2) bits of the fetch address and the tag is the remaining upper bits. Two addresses with the same index are held at the same time.
- R6: Each set keeps one LRU bit. A fill into a set with both ways valid replaces the way used least recently, where both hits and fills count as use. An invalid way is filled first, and way 0 is taken before way 1.
- R7: When `freeze` is high during the refill cycle, the instruction is delivered but not stored.
- R8: A one-cycle `flush` pulse invalidates every entry, so the next fetch of any address misses.
- R9: A hit with `data_req` low is also served from the store, with `bus_ifetch` 0.
- R10: In the refill cycle `bus_addr` is the address captured in the conflict cycle, whatever `fetch_addr` shows at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Sequencer requests an instruction |
| fetch_addr | input | AW | Instruction address |
| data_req | input | 1 | Data side wants the shared bus this cycle |
| freeze | input | 1 | Suppress allocation of new entries |
| flush | input | 1 | Invalidate all entries |
| instr_valid | output | 1 | `instr_data` carries the requested instruction |
| instr_data | output | DW | Instruction to the sequencer |
| fetch_stall | output | 1 | Fetch held one cycle by a bus conflict |
| bus_ifetch | output | 1 | Shared bus is used for an instruction read |
| bus_addr | output | AW | Instruction read address on the shared bus |
| bus_rdata | input | DW | Word returned by memory for `bus_addr`, same cycle |
| data_grant | output | 1 | Shared bus is given to the data access |

## Verification
A wrong valid bit, tag or LRU bit shows up at the ports on the next fetch to the affected set. A lost entry appears as an unexpected `fetch_stall` together with a bus read. A stale or wrong way appears as a hit that returns the wrong word. To expose a wrong way, the bench changes the memory contents after each fill, so a word served from the store can be told apart from a word fetched from memory. An eviction error surfaces within the third distinct fetch to a set. A refill address or ordering error appears one cycle after the conflict, on `bus_addr` and on `instr_data`.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_REFILL = 1'b1
  } icc_state_e;

  // Victim choice for a 2-way set: an empty way first (way 0 before way 1), otherwise the LRU way.
  function automatic logic pick_victim(input logic v0, input logic v1, input logic lru);
    if (!v0) return 1'b0;
    if (!v1) return 1'b1;
    return lru;
  endfunction

  // After a way is used, the other way becomes least recently used.
  function automatic logic lru_after_use(input logic used_way);
    return ~used_way;
  endfunction

endpackage

// File: rtl/icc_way.sv
module icc_way #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data,
  output logic [(1<<IDX_W)-1:0] valid_vec,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign hit       = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_data   = data_q[rd_idx];
  assign valid_vec = valid_q;

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> (valid_vec == '0) || !rst_n);

endmodule

// File: rtl/icc_lru.sv
module icc_lru #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             lru_way
);
  import icc_pkg::*;
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else if (touch) lru_q[touch_idx] <= lru_after_use(touch_way);
  end

  assign lru_way = lru_q[rd_idx];

  // R6
  lru_points_away_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> (lru_q[$past(touch_idx)] != $past(touch_way)));

endmodule

// File: rtl/icc_conflict_cache.sv
module icc_conflict_cache #(
  parameter int AW      = 24,
  parameter int DW      = 48,
  parameter int ENTRIES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  input  logic          data_req,
  input  logic          freeze,
  input  logic          flush,
  output logic          instr_valid,
  output logic [DW-1:0] instr_data,
  output logic          fetch_stall,
  output logic          bus_ifetch,
  output logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic          data_grant
);
  import icc_pkg::*;

  localparam int WAYS  = 2;
  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = AW - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [AW-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1:IDX_W];
  endfunction

  icc_state_e  state_q;
  logic [AW-1:0] pend_addr_q;

  logic [WAYS-1:0]            way_hit;
  logic [WAYS-1:0][DW-1:0]    way_data;
  logic [WAYS-1:0][SETS-1:0]  way_valid;
  logic [WAYS-1:0]            way_wr;

  // Named internal events
  logic any_hit, hit_ev, nc_miss_ev, conflict_ev, refill_ev, fill_ev;
  logic victim, lru_way, hit_way;
  logic [DW-1:0] hit_data;

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_way
      icc_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DW)) u_way (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .rd_idx    (idx_of(fetch_addr)),
        .rd_tag    (tag_of(fetch_addr)),
        .hit       (way_hit[w]),
        .rd_data   (way_data[w]),
        .valid_vec (way_valid[w]),
        .wr_en     (way_wr[w]),
        .wr_idx    (idx_of(pend_addr_q)),
        .wr_tag    (tag_of(pend_addr_q)),
        .wr_data   (bus_rdata)
      );
      assign way_wr[w] = fill_ev && (victim == 1'(w));
    end
  endgenerate

  icc_lru #(.IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (hit_ev || fill_ev),
    .touch_idx (hit_ev ? idx_of(fetch_addr) : idx_of(pend_addr_q)),
    .touch_way (hit_ev ? hit_way : victim),
    .rd_idx    (idx_of(pend_addr_q)),
    .lru_way   (lru_way)
  );

  assign any_hit     = |way_hit;
  assign hit_way     = way_hit[1];
  assign hit_data    = way_hit[1] ? way_data[1] : way_data[0];
  assign hit_ev      = (state_q == ST_LOOKUP) && fetch_req && any_hit;
  assign nc_miss_ev  = (state_q == ST_LOOKUP) && fetch_req && !any_hit && !data_req;
  assign conflict_ev = (state_q == ST_LOOKUP) && fetch_req && !any_hit && data_req;
  assign refill_ev   = (state_q == ST_REFILL);
  assign fill_ev     = refill_ev && !freeze && !flush;
  assign victim      = pick_victim(way_valid[0][idx_of(pend_addr_q)],
                                   way_valid[1][idx_of(pend_addr_q)], lru_way);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_LOOKUP;
      pend_addr_q <= '0;
    end else begin
      if (conflict_ev) begin
        state_q     <= ST_REFILL;
        pend_addr_q <= fetch_addr;
      end else if (refill_ev) begin
        state_q <= ST_LOOKUP;
      end
    end
  end

  assign instr_valid = hit_ev || nc_miss_ev || refill_ev;
  assign instr_data  = hit_ev ? hit_data : bus_rdata;
  assign fetch_stall = conflict_ev;
  assign bus_ifetch  = nc_miss_ev || refill_ev;
  assign bus_addr    = refill_ev ? pend_addr_q : fetch_addr;
  assign data_grant  = data_req && !bus_ifetch;

  // R3
  conflict_then_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> (bus_ifetch && instr_valid && !fetch_stall));

  // R10
  refill_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> (bus_addr == $past(fetch_addr)));

  // R3
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ifetch && data_grant));

  // R4
  hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && any_hit && !refill_ev) |-> (!bus_ifetch && !fetch_stall));

  // R5
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  // R2
  nc_miss_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nc_miss_ev && !flush) |=> (way_valid == $past(way_valid)));

  // R7
  freeze_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_ev && freeze && !flush) |=> (way_valid == $past(way_valid)));

endmodule

// File: tb/test_icc_conflict_cache.sv
module test_icc_conflict_cache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 48;
  localparam int K_HIT = 0, K_MISS = 1, K_CMISS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_req = 1'b0, data_req = 1'b0, freeze = 1'b0, flush = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          instr_valid, fetch_stall, bus_ifetch, data_grant;
  logic [DW-1:0] instr_data, bus_rdata;
  logic [AW-1:0] bus_addr;
  logic [AW-1:0] gen = '0;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  string         req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: word depends on address and a generation value the bench changes.
  always_comb bus_rdata = {bus_addr ^ gen, ~bus_addr};

  function automatic logic [DW-1:0] mw(input logic [AW-1:0] a, input logic [AW-1:0] g);
    return {a ^ g, ~a};
  endfunction

  icc_conflict_cache i_icc_conflict_cache (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .data_req(data_req), .freeze(freeze), .flush(flush),
    .instr_valid(instr_valid), .instr_data(instr_data), .fetch_stall(fetch_stall),
    .bus_ifetch(bus_ifetch), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .data_grant(data_grant)
  );

  task automatic check(input string rq, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Monitor: pops expected instruction words as the design delivers them.
  always @(negedge clk) begin
    if (rst_n && instr_valid) begin
      if (exp_q.size() == 0) begin
        check("R4", "unexpected instr_valid", 48'd1, 48'd0);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(r, "instr_data", instr_data, e);
      end
    end
  end

  // Driver: issues one fetch, pushes the expected word, checks bus behaviour.
  task automatic fetch(input logic [AW-1:0] a, input logic dq, input int kind,
                       input logic [DW-1:0] ev, input string rq);
    @(posedge clk); #1;
    fetch_req = 1'b1; fetch_addr = a; data_req = dq;
    exp_q.push_back(ev); req_q.push_back(rq);
    @(negedge clk);
    if (kind == K_HIT) begin
      check(rq, "hit stall", 48'(fetch_stall), 48'd0);
      check(rq, "hit bus_ifetch", 48'(bus_ifetch), 48'd0);
      check(rq, "hit data_grant", 48'(data_grant), 48'(dq));
    end else if (kind == K_MISS) begin
      check(rq, "miss stall", 48'(fetch_stall), 48'd0);
      check(rq, "miss bus_ifetch", 48'(bus_ifetch), 48'd1);
      check(rq, "miss bus_addr", 48'(bus_addr), 48'(a));
    end else begin
      check(rq, "conflict stall", 48'(fetch_stall), 48'd1);
      check(rq, "conflict data_grant", 48'(data_grant), 48'd1);
      check(rq, "conflict instr_valid", 48'(instr_valid), 48'd0);
      @(posedge clk); #1;
      fetch_addr = ~a;  // R10: refill must use the captured address
      @(negedge clk);
      check("R10", "refill bus_addr", 48'(bus_addr), 48'(a));
      check(rq, "refill bus_ifetch", 48'(bus_ifetch), 48'd1);
      check(rq, "refill data_grant", 48'(data_grant), 48'd0);
      check(rq, "refill stall", 48'(fetch_stall), 48'd0);
    end
    @(posedge clk); #1;
    fetch_req = 1'b0; data_req = 1'b0;
  endtask

  task automatic pulse_flush();
    @(posedge clk); #1; flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
  endtask

  localparam logic [AW-1:0] A = 24'h000010, B = 24'h000020, C = 24'h000030, D = 24'h000005;
  localparam logic [AW-1:0] G0 = 24'h0, G1 = 24'h111111, G2 = 24'h222222;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1", "reset instr_valid", 48'(instr_valid), 48'd0);
    check("R1", "reset stall", 48'(fetch_stall), 48'd0);
    check("R1", "reset bus_ifetch", 48'(bus_ifetch), 48'd0);

    fetch(A, 1'b0, K_MISS,  mw(A, G0), "R2");
    fetch(A, 1'b1, K_CMISS, mw(A, G0), "R2");   // R3: not allocated by plain miss
    gen = G1;
    fetch(A, 1'b1, K_HIT,   mw(A, G0), "R4");
    fetch(A, 1'b0, K_HIT,   mw(A, G0), "R9");
    fetch(B, 1'b1, K_CMISS, mw(B, G1), "R5");
    fetch(A, 1'b1, K_HIT,   mw(A, G0), "R5");
    fetch(B, 1'b1, K_HIT,   mw(B, G1), "R5");
    gen = G2;
    fetch(C, 1'b1, K_CMISS, mw(C, G2), "R6");   // evicts A (LRU)
    fetch(B, 1'b1, K_HIT,   mw(B, G1), "R6");
    fetch(A, 1'b1, K_CMISS, mw(A, G2), "R6");   // A was evicted; replaces C
    fetch(C, 1'b1, K_CMISS, mw(C, G2), "R6");   // C now evicted
    freeze = 1'b1;
    fetch(D, 1'b1, K_CMISS, mw(D, G2), "R7");
    freeze = 1'b0;
    fetch(D, 1'b1, K_CMISS, mw(D, G2), "R7");   // frozen refill stored nothing
    fetch(D, 1'b1, K_HIT,   mw(D, G2), "R7");
    pulse_flush();
    fetch(D, 1'b1, K_CMISS, mw(D, G2), "R8");
    fetch(C, 1'b1, K_CMISS, mw(C, G2), "R8");

    repeat (3) @(posedge clk);
    check("R4", "pending expectations", 48'(exp_q.size()), 48'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule